// File: doc/BRIEF.md
# Windowed Outbound Address Decoder

This block sits between a processor address bus and a secondary bus. The top 256 MB of the 32-bit processor space (0xF0000000 to 0xFFFFFFFF) is split into thirty-two 8 MB windows. Software programs a per-window enable mask and a control field. A processor address that lands in an enabled window is forwarded to the secondary bus, and its numeric value is not changed. Any other valid processor address is flagged as a miss, so that the system can send the access elsewhere.

A second, independent path classifies addresses that bus masters on the secondary bus present. Each address goes either to main memory or back onto the secondary bus, based on a fixed split point. Both decode paths are combinational. Only the two programming registers hold state. They are written and read over a simple register bus that uses a 12-bit offset.

Top module: `outbound_window_decoder`

## Requirements
- R1: After synchronous reset the control register and the enable register both read back as 0, and a valid processor address produces a miss with no hit.
- R2: A write to the enable register (offset 0x060) stores the written data ANDed with 0x7FFFFFFE, so bit 0 and bit 31 always read back as 0.
- R3: The control register (offset 0x038) reads back all 32 written bits. A read at any other offset returns 0.
- R4: A hit occurs only when control bits [8:7] equal 2'b01. The values 00, 10 and 11 suppress every window.
- R5: A processor address hits window i when address bits [31:28] are 0xF, bits [27:23] equal i, and enable bit i is set. The window number output then shows i.
- R6: On a hit the forwarded address equals the processor address. On no hit it is 0.
- R7: When the processor request is valid, exactly one of hit and miss is high. When it is not valid, both are low.
- R8: A valid bus-master address below 0xF0800000 is routed to memory. One at 0xF0800000 or above is routed to the secondary bus. The address is passed through unchanged, and with no valid request neither route is raised.
- R9: A register write changes the decode outcome starting with the cycle after the write edge, not before that edge.
- R10: Writes to offsets other than 0x038 and 0x060 change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpu_valid | input | 1 | Processor request present |
| cpu_addr | input | 32 | Processor address |
| fwd_hit | output | 1 | Address forwarded to secondary bus |
| fwd_miss | output | 1 | Valid address not in any enabled window |
| fwd_win | output | 5 | Window number of the hit |
| fwd_addr | output | 32 | Forwarded secondary bus address |
| bm_valid | input | 1 | Bus-master request present |
| bm_addr | input | 32 | Bus-master address |
| bm_to_mem | output | 1 | Route to main memory |
| bm_to_bus | output | 1 | Route to secondary bus |
| bm_addr_out | output | 32 | Routed bus-master address |

## Verification
The assertions check four things on every cycle. The two edge windows can never be enabled. A hit always has the correct control code, a set enable bit and a matching window field. Hit and miss, and the memory and bus routes, are mutually exclusive and complete. A write to the enable register shows its masked value one cycle later. The bench scenarios are needed to show which specific addresses hit which windows, the exact boundary values of the bus-master split, readback of unmapped offsets, and that writes to other offsets leave the state alone.

// File: rtl/owd_pkg.sv
package owd_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned WIN_LOG2  = 23;
    localparam int unsigned TAG_W     = 4;
    localparam int unsigned WIN_IDX_W = ADDR_W - TAG_W - WIN_LOG2;
    localparam int unsigned NUM_WIN   = 1 << WIN_IDX_W;
    localparam int unsigned OFF_W     = 12;
    localparam int unsigned CTRL_LO   = 7;

    localparam logic [TAG_W-1:0]  REGION_TAG = 4'hF;
    localparam logic [OFF_W-1:0]  OFF_CTRL   = 12'h038;
    localparam logic [OFF_W-1:0]  OFF_WEN    = 12'h060;
    localparam logic [ADDR_W-1:0] WEN_KEEP   = 32'h7FFF_FFFE;
    localparam logic [1:0]        FWD_ON     = 2'b01;
    localparam logic [ADDR_W-1:0] BM_SPLIT   = 32'hF080_0000;

    typedef struct packed {
        logic                 hit;
        logic                 miss;
        logic [WIN_IDX_W-1:0] win;
        logic [ADDR_W-1:0]    addr;
    } fwd_res_t;

    typedef struct packed {
        logic              to_mem;
        logic              to_bus;
        logic [ADDR_W-1:0] addr;
    } bm_res_t;

    function automatic logic fwd_enabled(input logic [ADDR_W-1:0] ctrl);
        return ctrl[CTRL_LO+1:CTRL_LO] == FWD_ON;
    endfunction
endpackage

// File: rtl/owd_regs.sv
module owd_regs
    import owd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] io_ctrl,
    output logic [ADDR_W-1:0] win_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            io_ctrl <= '0;
            win_en  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFF_CTRL) io_ctrl <= reg_wdata;
            if (reg_addr == OFF_WEN)  win_en  <= reg_wdata & WEN_KEEP;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_CTRL: reg_rdata = io_ctrl;
            OFF_WEN:  reg_rdata = win_en;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/owd_fwd_match.sv
module owd_fwd_match
    import owd_pkg::*;
(
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] io_ctrl,
    input  logic [ADDR_W-1:0] win_en,
    output fwd_res_t          res
);
    logic                 in_region;
    logic [WIN_IDX_W-1:0] idx;
    logic [NUM_WIN-1:0]   win_hit;
    logic                 any_hit;

    assign in_region = cpu_addr[ADDR_W-1 -: TAG_W] == REGION_TAG;
    assign idx       = cpu_addr[ADDR_W-TAG_W-1 -: WIN_IDX_W];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign win_hit[i] = in_region && (idx == WIN_IDX_W'(i)) && win_en[i];
    end

    assign any_hit = cpu_valid && fwd_enabled(io_ctrl) && (|win_hit);

    always_comb begin
        res.hit  = any_hit;
        res.miss = cpu_valid && !any_hit;
        res.win  = any_hit ? idx : '0;
        res.addr = any_hit ? cpu_addr : '0;
    end
endmodule

// File: rtl/owd_bm_route.sv
module owd_bm_route
    import owd_pkg::*;
(
    input  logic              bm_valid,
    input  logic [ADDR_W-1:0] bm_addr,
    output bm_res_t           res
);
    logic upper;
    assign upper = bm_addr >= BM_SPLIT;

    always_comb begin
        res.to_mem = bm_valid && !upper;
        res.to_bus = bm_valid && upper;
        res.addr   = bm_addr;
    end
endmodule

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder
    import owd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [OFF_W-1:0]     reg_addr,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    input  logic                 cpu_valid,
    input  logic [ADDR_W-1:0]    cpu_addr,
    output logic                 fwd_hit,
    output logic                 fwd_miss,
    output logic [WIN_IDX_W-1:0] fwd_win,
    output logic [ADDR_W-1:0]    fwd_addr,
    input  logic                 bm_valid,
    input  logic [ADDR_W-1:0]    bm_addr,
    output logic                 bm_to_mem,
    output logic                 bm_to_bus,
    output logic [ADDR_W-1:0]    bm_addr_out
);
    logic [ADDR_W-1:0] io_ctrl;
    logic [ADDR_W-1:0] win_en;
    fwd_res_t          fres;
    bm_res_t           bres;

    owd_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .io_ctrl(io_ctrl), .win_en(win_en)
    );

    owd_fwd_match u_match (
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .io_ctrl(io_ctrl), .win_en(win_en), .res(fres)
    );

    owd_bm_route u_route (
        .bm_valid(bm_valid), .bm_addr(bm_addr), .res(bres)
    );

    assign fwd_hit     = fres.hit;
    assign fwd_miss    = fres.miss;
    assign fwd_win     = fres.win;
    assign fwd_addr    = fres.addr;
    assign bm_to_mem   = bres.to_mem;
    assign bm_to_bus   = bres.to_bus;
    assign bm_addr_out = bres.addr;
endmodule

// File: rtl/owd_checker.sv
module owd_checker
    import owd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [OFF_W-1:0]     reg_addr,
    input logic [ADDR_W-1:0]    reg_wdata,
    input logic [ADDR_W-1:0]    io_ctrl,
    input logic [ADDR_W-1:0]    win_en,
    input logic                 cpu_valid,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic                 fwd_hit,
    input logic                 fwd_miss,
    input logic [WIN_IDX_W-1:0] fwd_win,
    input logic [ADDR_W-1:0]    fwd_addr,
    input logic                 bm_valid,
    input logic [ADDR_W-1:0]    bm_addr,
    input logic                 bm_to_mem,
    input logic                 bm_to_bus,
    input logic [ADDR_W-1:0]    bm_addr_out
);
    a_r2_edges_off: assert property (@(posedge clk) disable iff (rst)
        !win_en[0] && !win_en[NUM_WIN-1]);

    a_r4_gate: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> io_ctrl[CTRL_LO+1:CTRL_LO] == FWD_ON);

    a_r5_window: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> (win_en[fwd_win] && cpu_addr[ADDR_W-1 -: TAG_W] == REGION_TAG
                     && cpu_addr[ADDR_W-TAG_W-1 -: WIN_IDX_W] == fwd_win));

    a_r6_same_addr: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> fwd_addr == cpu_addr);

    a_r7_one_flag: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |-> $onehot({fwd_hit, fwd_miss}));

    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        !cpu_valid |-> !fwd_hit && !fwd_miss);

    a_r8_route: assert property (@(posedge clk) disable iff (rst)
        bm_valid |-> (bm_to_bus == (bm_addr >= BM_SPLIT)) && (bm_to_mem != bm_to_bus));

    a_r8_pass: assert property (@(posedge clk) disable iff (rst)
        bm_addr_out == bm_addr);

    a_r9_wen_next: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_WEN) |=> win_en == ($past(reg_wdata) & WEN_KEEP));
endmodule

bind outbound_window_decoder owd_checker u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .io_ctrl(io_ctrl), .win_en(win_en),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .fwd_hit(fwd_hit),
    .fwd_miss(fwd_miss), .fwd_win(fwd_win), .fwd_addr(fwd_addr),
    .bm_valid(bm_valid), .bm_addr(bm_addr), .bm_to_mem(bm_to_mem),
    .bm_to_bus(bm_to_bus), .bm_addr_out(bm_addr_out)
);

// File: tb/outbound_window_decoder_test.sv
module outbound_window_decoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        cpu_valid;
    logic [31:0] cpu_addr;
    logic        fwd_hit, fwd_miss;
    logic [4:0]  fwd_win;
    logic [31:0] fwd_addr;
    logic        bm_valid;
    logic [31:0] bm_addr;
    logic        bm_to_mem, bm_to_bus;
    logic [31:0] bm_addr_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    outbound_window_decoder uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .fwd_hit(fwd_hit), .fwd_miss(fwd_miss), .fwd_win(fwd_win),
        .fwd_addr(fwd_addr), .bm_valid(bm_valid), .bm_addr(bm_addr),
        .bm_to_mem(bm_to_mem), .bm_to_bus(bm_to_bus), .bm_addr_out(bm_addr_out)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] en;
        logic [31:0] addr;
        logic        hit;
        logic [4:0]  win;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0080, 32'h0000_0002, 32'hF081_2345, 1'b1, 5'd1},
        '{32'h0000_0080, 32'h0000_0002, 32'hF100_0000, 1'b0, 5'd0},
        '{32'h0000_0180, 32'h0000_0002, 32'hF080_0000, 1'b0, 5'd0},
        '{32'h0000_0100, 32'h0000_0002, 32'hF080_0000, 1'b0, 5'd0},
        '{32'h0000_0080, 32'h4000_0000, 32'hFF7F_FFFF, 1'b1, 5'd30},
        '{32'h0000_0080, 32'hFFFF_FFFF, 32'hFF80_0000, 1'b0, 5'd0},
        '{32'h0000_0080, 32'hFFFF_FFFF, 32'hF000_0000, 1'b0, 5'd0},
        '{32'h0000_0080, 32'hFFFF_FFFF, 32'hEF80_0000, 1'b0, 5'd0},
        '{32'hFFFF_FEFF, 32'h0010_0000, 32'hFA01_2345, 1'b1, 5'd20}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        cpu_valid = 1'b0; cpu_addr = '0; bm_valid = 1'b0; bm_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h038, d); check("R1 ctrl", d, 32'h0);
        rd(12'h060, d); check("R1 wen", d, 32'h0);
        cpu_valid = 1'b1; cpu_addr = 32'hF080_0000; #1;
        check("R1 hit/miss", {30'h0, fwd_hit, fwd_miss}, 32'h1);

        // Vector table: R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            wr(12'h038, VECS[k].ctrl);
            wr(12'h060, VECS[k].en);
            cpu_valid = 1'b1; cpu_addr = VECS[k].addr; #1;
            check("R4/R5 hit", {31'h0, fwd_hit}, {31'h0, VECS[k].hit});
            check("R7 miss", {31'h0, fwd_miss}, {31'h0, ~VECS[k].hit});
            check("R5 win", {27'h0, fwd_win}, {27'h0, VECS[k].win});
            check("R6 addr", fwd_addr, VECS[k].hit ? VECS[k].addr : 32'h0);
        end

        // R2 masking on readback
        wr(12'h060, 32'hFFFF_FFFF);
        rd(12'h060, d); check("R2 wen mask", d, 32'h7FFF_FFFE);
        // R3 full control readback and unmapped read
        rd(12'h038, d); check("R3 ctrl", d, 32'hFFFF_FEFF);
        rd(12'h044, d); check("R3 unmapped", d, 32'h0);

        // R10 write to other offsets ignored
        wr(12'h044, 32'h0000_0000);
        wr(12'h03C, 32'h0000_0000);
        wr(12'h064, 32'h0000_0000);
        rd(12'h038, d); check("R10 ctrl kept", d, 32'hFFFF_FEFF);
        rd(12'h060, d); check("R10 wen kept", d, 32'h7FFF_FFFE);

        // R7 idle request
        cpu_valid = 1'b0; cpu_addr = 32'hF080_0000; #1;
        check("R7 idle", {30'h0, fwd_hit, fwd_miss}, 32'h0);

        // R9 write timing: disable via control, visible only after the edge
        cpu_valid = 1'b1; cpu_addr = 32'hF080_0000;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h038; reg_wdata = 32'h0;
        #1 check("R9 before edge", {31'h0, fwd_hit}, 32'h1);
        @(negedge clk);
        reg_wr = 1'b0;
        #1 check("R9 after edge", {31'h0, fwd_hit}, 32'h0);

        // R8 bus-master routing
        bm_valid = 1'b1;
        bm_addr = 32'hF07F_FFFF; #1;
        check("R8 below split", {30'h0, bm_to_mem, bm_to_bus}, 32'h2);
        bm_addr = 32'hF080_0000; #1;
        check("R8 at split", {30'h0, bm_to_mem, bm_to_bus}, 32'h1);
        bm_addr = 32'h0000_0000; #1;
        check("R8 zero", {30'h0, bm_to_mem, bm_to_bus}, 32'h2);
        bm_addr = 32'hFFFF_FFFF; #1;
        check("R8 top", {30'h0, bm_to_mem, bm_to_bus}, 32'h1);
        check("R8 pass", bm_addr_out, 32'hFFFF_FFFF);
        bm_valid = 1'b0; #1;
        check("R8 idle", {30'h0, bm_to_mem, bm_to_bus}, 32'h0);

        // R1 reset clears after programming
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(12'h060, d); check("R1 wen after reset", d, 32'h0);

        finish_run();
    end
endmodule